// File: doc/BRIEF.md
# LVDS Control Bit and Lane Router

This block sits in front of a serial display transmitter. It picks which display timing signal drives each of four control slots, and it decides which incoming pixel data lane feeds each of four outgoing lanes. The timing sources are horizontal sync, vertical sync, display enable, the odd-field flag and composite data enable, plus a constant zero. Each slot accepts a different subset of these sources, and each slot numbers its subset in its own way.

Two configuration words sit behind a simple register port. Software writes them once per mode set, before the link is brought up. The control word gives a 3-bit source code for each slot. The lane word gives, for each output lane, a 2-bit rotation. This rotation is the distance from the output index to the source lane, modulo four. It is not the source lane number itself. All outputs are registered, and the serializer that follows receives them one clock after the inputs are sampled.

Top module: `lvr_router`

## Requirements
- R1: While reset is high and on the first cycle after it, the control outputs and the lane outputs are zero. The control word reads back 0x0000 and the lane word reads back 0x2020.
- R2: Slot 0 (control word bits 2:0) selects hsync for code 0, vsync for 1, display enable for 2, odd for 3 and composite DE for 4.
- R3: Slot 1 (bits 6:4) selects vsync for code 0, display enable for 1, odd for 2, composite DE for 3 and hsync for 4.
- R4: Slot 2 (bits 10:8) selects display enable for code 0, odd for 1, composite DE for 2, hsync for 3 and vsync for 4.
- R5: Slot 3 (bits 14:12) gives constant 0 for code 0, odd for code 1 and composite DE for code 2.
- R6: Any code outside a slot's list drives 0 on that slot: codes 5 to 7 on slots 0 to 2, and codes 3 to 7 on slot 3.
- R7: Output lane n takes input lane (n + f) mod 4, where f is the 2-bit field at lane word bits 4n+1:4n. Several outputs may name the same source lane, and each of them then carries a copy of it.
- R8: The reset lane word 0x2020 exchanges lanes 1 and 3 and passes lanes 0 and 2 straight through. The reset control word maps hsync, vsync, display enable and zero onto slots 0 to 3.
- R9: Each output shows the inputs sampled at the previous rising clock edge. This gives exactly one cycle of latency.
- R10: A write (reg_we high) to offset 0x0C or 0x10 updates the word at that clock edge, and the outputs use the new value from the next edge on. Unused bits are not stored and read back as 0. Read data shows the word at reg_addr one cycle after the address is applied.
- R11: A write to any other offset changes neither word. A read of any other offset returns 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | Register byte offset |
| reg_wdata | input | DATA_W | Register write data |
| reg_rdata | output | DATA_W | Registered read data for reg_addr |
| hsync_i | input | 1 | Horizontal sync |
| vsync_i | input | 1 | Vertical sync |
| de_i | input | 1 | Display enable |
| odd_i | input | 1 | Odd-field flag |
| cde_i | input | 1 | Composite data enable |
| lanes_i | input | 4*LANE_W | Input data lanes, lane k at bits k*LANE_W upward |
| ctl_o | output | 4 | Control slot outputs, slot s on bit s |
| lanes_o | output | 4*LANE_W | Routed output lanes, same packing as lanes_i |

## Verification
The assertions assume that every input is a known 0 or 1 at each rising edge. They also assume that the cycle before each checked edge was not a reset cycle, and they track this with a flag so that nothing is compared against a register that was being cleared. The stimulus changes inputs and register strobes only on falling edges, so each edge samples a stable value. Between writes it leaves reg_we low, which lets the hold checks see the configuration words stay unchanged.

// File: rtl/lvr_pkg.sv
package lvr_pkg;

  localparam int NUM_SLOTS   = 4;
  localparam int NUM_LANES   = 4;
  localparam int CODE_W      = 3;
  localparam int LSEL_W      = $clog2(NUM_LANES);
  localparam int FIELD_PITCH = 4;
  localparam int CFG_W       = NUM_SLOTS * FIELD_PITCH;
  localparam int NUM_SRC     = 5;

  // Bit positions of the timing source vector
  typedef enum logic [2:0] {
    SRC_HS  = 3'd0,
    SRC_VS  = 3'd1,
    SRC_DE  = 3'd2,
    SRC_ODD = 3'd3,
    SRC_CDE = 3'd4
  } src_e;

  // Mask with 'width' low bits set in every field of the word
  function automatic logic [CFG_W-1:0] field_mask(int width);
    logic [CFG_W-1:0] m;
    m = '0;
    for (int i = 0; i < NUM_SLOTS; i++)
      for (int b = 0; b < width; b++)
        m[i*FIELD_PITCH + b] = 1'b1;
    return m;
  endfunction

  // Reset lane word: lanes 1 and 3 exchanged, 0 and 2 straight
  function automatic logic [CFG_W-1:0] lane_reset_word();
    logic [CFG_W-1:0] w;
    int src;
    w = '0;
    for (int n = 0; n < NUM_LANES; n++) begin
      src = (n == 1) ? 3 : (n == 3) ? 1 : n;
      w[n*FIELD_PITCH +: LSEL_W] = LSEL_W'((src - n + NUM_LANES) % NUM_LANES);
    end
    return w;
  endfunction

  // Slots 0..2 walk the same five sources, each starting one further along.
  // The last slot offers only zero, odd and composite DE.
  function automatic logic slot_pick(int slot, logic [CODE_W-1:0] code,
                                     logic [NUM_SRC-1:0] sigs);
    logic r;
    r = 1'b0;
    if (slot == NUM_SLOTS-1) begin
      case (code)
        3'd1:    r = sigs[SRC_ODD];
        3'd2:    r = sigs[SRC_CDE];
        default: r = 1'b0;
      endcase
    end else if (int'(code) < NUM_SRC) begin
      for (int k = 0; k < NUM_SRC; k++)
        if (k == (int'(code) + slot) % NUM_SRC) r = sigs[k];
    end
    return r;
  endfunction

endpackage

// File: rtl/lvr_regs.sv
module lvr_regs
  import lvr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int CTL_OFS  = 'h0C,
  parameter int LANE_OFS = 'h10
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              reg_we,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CFG_W-1:0]  ctl_cfg,
  output logic [CFG_W-1:0]  lane_cfg
);

  localparam logic [CFG_W-1:0]  CTL_MASK  = field_mask(CODE_W);
  localparam logic [CFG_W-1:0]  LANE_MASK = field_mask(LSEL_W);
  localparam logic [CFG_W-1:0]  LANE_RST  = lane_reset_word();
  localparam logic [ADDR_W-1:0] CTL_A     = ADDR_W'(CTL_OFS);
  localparam logic [ADDR_W-1:0] LANE_A    = ADDR_W'(LANE_OFS);

  logic hit_ctl, hit_lane;
  logic [CFG_W-1:0] rd_mux;

  assign hit_ctl  = (reg_addr == CTL_A);
  assign hit_lane = (reg_addr == LANE_A);

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl_cfg  <= '0;
      lane_cfg <= LANE_RST;
    end else if (reg_we) begin
      if (hit_ctl)  ctl_cfg  <= reg_wdata[CFG_W-1:0] & CTL_MASK;
      if (hit_lane) lane_cfg <= reg_wdata[CFG_W-1:0] & LANE_MASK;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctl)  rd_mux = ctl_cfg;
    if (hit_lane) rd_mux = lane_cfg;
  end

  always_ff @(posedge clk) begin
    if (rst) reg_rdata <= '0;
    else     reg_rdata <= {{(DATA_W-CFG_W){1'b0}}, rd_mux};
  end

endmodule

// File: rtl/lvr_ctl_mux.sv
module lvr_ctl_mux
  import lvr_pkg::*;
(
  input  logic               clk,
  input  logic               rst,
  input  logic [CFG_W-1:0]   ctl_cfg,
  input  logic [NUM_SRC-1:0] sigs,
  output logic [NUM_SLOTS-1:0] ctl_o
);

  for (genvar s = 0; s < NUM_SLOTS; s++) begin : g_slot
    logic [CODE_W-1:0] code;
    logic              pick;

    assign code = ctl_cfg[s*FIELD_PITCH +: CODE_W];

    always_comb pick = slot_pick(s, code, sigs);

    always_ff @(posedge clk) begin
      if (rst) ctl_o[s] <= 1'b0;
      else     ctl_o[s] <= pick;
    end
  end

endmodule

// File: rtl/lvr_lane_mux.sv
module lvr_lane_mux
  import lvr_pkg::*;
#(
  parameter int LANE_W = 7
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [CFG_W-1:0]            lane_cfg,
  input  logic [NUM_LANES*LANE_W-1:0] lanes_i,
  output logic [NUM_LANES*LANE_W-1:0] lanes_o
);

  for (genvar n = 0; n < NUM_LANES; n++) begin : g_lane
    logic [LSEL_W-1:0] rot;
    logic [LSEL_W-1:0] src;
    logic [LANE_W-1:0] data;

    assign rot = lane_cfg[n*FIELD_PITCH +: LSEL_W];
    // The sum wraps at the lane count because it is LSEL_W bits wide
    assign src = LSEL_W'(n) + rot;

    always_comb begin
      data = '0;
      for (int k = 0; k < NUM_LANES; k++)
        if (src == LSEL_W'(k)) data = lanes_i[k*LANE_W +: LANE_W];
    end

    always_ff @(posedge clk) begin
      if (rst) lanes_o[n*LANE_W +: LANE_W] <= '0;
      else     lanes_o[n*LANE_W +: LANE_W] <= data;
    end
  end

endmodule

// File: rtl/lvr_router.sv
module lvr_router
  import lvr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int LANE_W   = 7,
  parameter int CTL_OFS  = 'h0C,
  parameter int LANE_OFS = 'h10
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic                        reg_we,
  input  logic [ADDR_W-1:0]           reg_addr,
  input  logic [DATA_W-1:0]           reg_wdata,
  output logic [DATA_W-1:0]           reg_rdata,
  input  logic                        hsync_i,
  input  logic                        vsync_i,
  input  logic                        de_i,
  input  logic                        odd_i,
  input  logic                        cde_i,
  input  logic [NUM_LANES*LANE_W-1:0] lanes_i,
  output logic [NUM_SLOTS-1:0]        ctl_o,
  output logic [NUM_LANES*LANE_W-1:0] lanes_o
);

  logic [CFG_W-1:0]   ctl_cfg;
  logic [CFG_W-1:0]   lane_cfg;
  logic [NUM_SRC-1:0] sigs;

  always_comb begin
    sigs          = '0;
    sigs[SRC_HS]  = hsync_i;
    sigs[SRC_VS]  = vsync_i;
    sigs[SRC_DE]  = de_i;
    sigs[SRC_ODD] = odd_i;
    sigs[SRC_CDE] = cde_i;
  end

  lvr_regs #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .CTL_OFS (CTL_OFS),
    .LANE_OFS(LANE_OFS)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .reg_we   (reg_we),
    .reg_addr (reg_addr),
    .reg_wdata(reg_wdata),
    .reg_rdata(reg_rdata),
    .ctl_cfg  (ctl_cfg),
    .lane_cfg (lane_cfg)
  );

  lvr_ctl_mux u_ctl (
    .clk    (clk),
    .rst    (rst),
    .ctl_cfg(ctl_cfg),
    .sigs   (sigs),
    .ctl_o  (ctl_o)
  );

  lvr_lane_mux #(.LANE_W(LANE_W)) u_lane (
    .clk     (clk),
    .rst     (rst),
    .lane_cfg(lane_cfg),
    .lanes_i (lanes_i),
    .lanes_o (lanes_o)
  );

endmodule

// File: rtl/lvr_router_chk.sv
module lvr_router_chk
  import lvr_pkg::*;
#(
  parameter int ADDR_W   = 8,
  parameter int DATA_W   = 32,
  parameter int LANE_W   = 7,
  parameter int CTL_OFS  = 'h0C,
  parameter int LANE_OFS = 'h10
) (
  input logic                        clk,
  input logic                        rst,
  input logic                        reg_we,
  input logic [ADDR_W-1:0]           reg_addr,
  input logic [DATA_W-1:0]           reg_wdata,
  input logic [DATA_W-1:0]           reg_rdata,
  input logic                        hsync_i,
  input logic                        odd_i,
  input logic                        cde_i,
  input logic [NUM_LANES*LANE_W-1:0] lanes_i,
  input logic [NUM_SLOTS-1:0]        ctl_o,
  input logic [NUM_LANES*LANE_W-1:0] lanes_o,
  input logic [CFG_W-1:0]            ctl_cfg,
  input logic [CFG_W-1:0]            lane_cfg
);

  // High when the previous edge was not a reset edge
  logic seen;
  always_ff @(posedge clk) begin
    if (rst) seen <= 1'b0;
    else     seen <= 1'b1;
  end

  AST_RESET_LANE_WORD: assert property (@(posedge clk) disable iff (rst)
    !seen |-> lane_cfg == 16'h2020) else $error("lane reset word");                  // R8

  AST_RESET_CTL_WORD: assert property (@(posedge clk) disable iff (rst)
    !seen |-> ctl_cfg == 16'h0000) else $error("ctl reset word");                    // R1

  AST_SLOT0_HSYNC: assert property (@(posedge clk) disable iff (rst)
    seen && $past(ctl_cfg[2:0]) == 3'd0 |-> ctl_o[0] == $past(hsync_i)) else $error("slot0"); // R2

  AST_SLOT3_ODD: assert property (@(posedge clk) disable iff (rst)
    seen && $past(ctl_cfg[14:12]) == 3'd1 |-> ctl_o[3] == $past(odd_i)) else $error("slot3 odd"); // R5

  AST_SLOT3_CDE: assert property (@(posedge clk) disable iff (rst)
    seen && $past(ctl_cfg[14:12]) == 3'd2 |-> ctl_o[3] == $past(cde_i)) else $error("slot3 cde"); // R5

  AST_SLOT3_UNLISTED: assert property (@(posedge clk) disable iff (rst)
    seen && ($past(ctl_cfg[14:12]) == 3'd0 || $past(ctl_cfg[14:12]) >= 3'd3) |-> !ctl_o[3]) else $error("slot3 zero"); // R6

  AST_CFG_HOLD: assert property (@(posedge clk) disable iff (rst)
    seen && !$past(reg_we) |-> $stable(ctl_cfg) && $stable(lane_cfg)) else $error("cfg hold"); // R10

  AST_CTL_WRITE: assert property (@(posedge clk) disable iff (rst)
    seen && $past(reg_we) && $past(reg_addr) == ADDR_W'(CTL_OFS)
      |-> ctl_cfg == ($past(reg_wdata[CFG_W-1:0]) & 16'h7777)) else $error("ctl write"); // R10

  AST_OTHER_ADDR_READ: assert property (@(posedge clk) disable iff (rst)
    seen && $past(reg_addr) != ADDR_W'(CTL_OFS) && $past(reg_addr) != ADDR_W'(LANE_OFS)
      |-> reg_rdata == '0) else $error("stray read"); // R11

  for (genvar n = 0; n < NUM_LANES; n++) begin : g_n
    for (genvar f = 0; f < NUM_LANES; f++) begin : g_f
      AST_LANE_ROUTE: assert property (@(posedge clk) disable iff (rst)
        seen && $past(lane_cfg[n*FIELD_PITCH +: LSEL_W]) == LSEL_W'(f)
          |-> lanes_o[n*LANE_W +: LANE_W] == $past(lanes_i[((n+f)%NUM_LANES)*LANE_W +: LANE_W]))
        else $error("lane route"); // R7
    end
  end

endmodule

bind lvr_router lvr_router_chk #(
  .ADDR_W  (ADDR_W),
  .DATA_W  (DATA_W),
  .LANE_W  (LANE_W),
  .CTL_OFS (CTL_OFS),
  .LANE_OFS(LANE_OFS)
) u_chk (
  .clk      (clk),
  .rst      (rst),
  .reg_we   (reg_we),
  .reg_addr (reg_addr),
  .reg_wdata(reg_wdata),
  .reg_rdata(reg_rdata),
  .hsync_i  (hsync_i),
  .odd_i    (odd_i),
  .cde_i    (cde_i),
  .lanes_i  (lanes_i),
  .ctl_o    (ctl_o),
  .lanes_o  (lanes_o),
  .ctl_cfg  (ctl_cfg),
  .lane_cfg (lane_cfg)
);

// File: tb/tb_lvr_router.sv
`timescale 1ns/1ps
module tb_lvr_router;

  localparam int AW = 8;
  localparam int DW = 32;
  localparam int LW = 7;
  localparam logic [AW-1:0] A_CTL  = 8'h0C;
  localparam logic [AW-1:0] A_LANE = 8'h10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          reg_we = 1'b0;
  logic [AW-1:0] reg_addr = '0;
  logic [DW-1:0] reg_wdata = '0;
  logic [DW-1:0] reg_rdata;
  logic          hsync_i = 0, vsync_i = 0, de_i = 0, odd_i = 0, cde_i = 0;
  logic [4*LW-1:0] lanes_i = '0;
  logic [3:0]      ctl_o;
  logic [4*LW-1:0] lanes_o;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  lvr_router dut (
    .clk(clk), .rst(rst), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .hsync_i(hsync_i), .vsync_i(vsync_i), .de_i(de_i), .odd_i(odd_i), .cde_i(cde_i),
    .lanes_i(lanes_i), .ctl_o(ctl_o), .lanes_o(lanes_o)
  );

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(logic [AW-1:0] a, logic [DW-1:0] d);
    @(negedge clk); reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk); reg_we = 1'b0;
  endtask

  task automatic rd(logic [AW-1:0] a, output logic [DW-1:0] d);
    @(negedge clk); reg_addr = a;
    @(posedge clk); #1 d = reg_rdata;
  endtask

  // sig bits: 0 hs, 1 vs, 2 de, 3 odd, 4 cde
  task automatic apply(logic [4:0] s, logic [4*LW-1:0] l);
    @(negedge clk);
    {cde_i, odd_i, de_i, vsync_i, hsync_i} = s;
    lanes_i = l;
    @(posedge clk); #1;
  endtask

  // Reference tables taken from the requirement text
  function automatic logic ref_slot(int slot, int code, logic [4:0] s);
    logic hs, vs, de, od, cd;
    {cd, od, de, vs, hs} = s;
    case (slot)
      0: case (code) 0: return hs; 1: return vs; 2: return de; 3: return od; 4: return cd; default: return 0; endcase
      1: case (code) 0: return vs; 1: return de; 2: return od; 3: return cd; 4: return hs; default: return 0; endcase
      2: case (code) 0: return de; 1: return od; 2: return cd; 3: return hs; 4: return vs; default: return 0; endcase
      default: case (code) 1: return od; 2: return cd; default: return 0; endcase
    endcase
  endfunction

  function automatic logic [4*LW-1:0] pack_lanes(logic [LW-1:0] a, b, c, d);
    return {d, c, b, a};
  endfunction

  localparam logic [4*LW-1:0] LIN = {7'h44, 7'h33, 7'h22, 7'h11};

  function automatic logic [LW-1:0] lane_of(logic [4*LW-1:0] v, int k);
    return v[k*LW +: LW];
  endfunction

  task automatic t_reset();
    logic [DW-1:0] d;
    rst = 1'b1;
    {cde_i, odd_i, de_i, vsync_i, hsync_i} = 5'h1F;
    lanes_i = LIN;
    repeat (3) @(posedge clk);
    #1;
    chk("R1 ctl in reset", 32'(ctl_o), 0);
    chk("R1 lanes in reset", 32'(lanes_o), 0);
    @(negedge clk); rst = 1'b0;
    {cde_i, odd_i, de_i, vsync_i, hsync_i} = 5'h0;
    rd(A_CTL, d);  chk("R1 ctl word", d, 32'h0000);
    rd(A_LANE, d); chk("R1 lane word", d, 32'h2020);
  endtask

  task automatic t_defaults();
    apply(5'b00111, LIN); // hs, vs, de high
    chk("R8 default ctl", 32'(ctl_o), 32'b0111);
    chk("R8 default lanes", 32'(lanes_o), 32'(pack_lanes(7'h11, 7'h44, 7'h33, 7'h22)));
  endtask

  task automatic t_codes(int slot, string tag);
    for (int code = 0; code < 8; code++) begin
      wr(A_CTL, 32'(code) << (slot*4));
      for (int p = 0; p < 32; p++) begin
        logic [4:0] s = 5'(p);
        apply(s, LIN);
        chk(tag, 32'(ctl_o[slot]), 32'(ref_slot(slot, code, s)));
        // other slots hold code 0
        chk(tag, 32'(ctl_o[3]), 32'(slot == 3 ? ref_slot(3, code, s) : 1'b0));
      end
    end
  endtask

  task automatic t_unlisted();
    wr(A_CTL, 32'h3555);
    apply(5'h1F, LIN);
    chk("R6 codes 5 and 3 give zero", 32'(ctl_o), 0);
    wr(A_CTL, 32'h7777);
    apply(5'h1F, LIN);
    chk("R6 code 7 gives zero", 32'(ctl_o), 0);
  endtask

  task automatic t_rotation();
    logic [DW-1:0] w;
    for (int r = 0; r < 4; r++) begin
      w = 32'(r) * 32'h1111;
      wr(A_LANE, w);
      apply(5'h0, LIN);
      for (int n = 0; n < 4; n++)
        chk("R7 rotation", 32'(lane_of(lanes_o, n)), 32'(lane_of(LIN, (n + r) % 4)));
    end
    wr(A_LANE, 32'h3012); // every output names input lane 2
    apply(5'h0, LIN);
    for (int n = 0; n < 4; n++)
      chk("R7 duplicate", 32'(lane_of(lanes_o, n)), 32'h33);
  endtask

  task automatic t_latency();
    wr(A_CTL, 32'h0);
    wr(A_LANE, 32'h0);
    apply(5'h0, '0);
    @(negedge clk);
    hsync_i = 1'b1; lanes_i = LIN;
    #1;
    chk("R9 before edge ctl", 32'(ctl_o[0]), 0);
    chk("R9 before edge lanes", 32'(lanes_o), 0);
    @(posedge clk); #1;
    chk("R9 after edge ctl", 32'(ctl_o[0]), 1);
    chk("R9 after edge lanes", 32'(lanes_o), 32'(LIN));
    hsync_i = 1'b0;
  endtask

  task automatic t_write_timing();
    logic [DW-1:0] d;
    wr(A_CTL, 32'h0);
    // write slot0 := vsync while hsync=0 vsync=1; edge of write still uses old code
    @(negedge clk);
    reg_we = 1'b1; reg_addr = A_CTL; reg_wdata = 32'h1;
    {cde_i, odd_i, de_i, vsync_i, hsync_i} = 5'b00010;
    @(posedge clk); #1;
    chk("R10 old code on write edge", 32'(ctl_o[0]), 0);
    @(negedge clk); reg_we = 1'b0;
    @(posedge clk); #1;
    chk("R10 new code next edge", 32'(ctl_o[0]), 1);
    wr(A_CTL, 32'hFFFF_FFFF);
    rd(A_CTL, d);  chk("R10 ctl reserved bits", d, 32'h7777);
    wr(A_LANE, 32'hFFFF_FFFF);
    rd(A_LANE, d); chk("R10 lane reserved bits", d, 32'h3333);
  endtask

  task automatic t_stray();
    logic [DW-1:0] d;
    wr(A_CTL, 32'h0123);
    wr(A_LANE, 32'h1032);
    wr(8'h14, 32'hFFFF_FFFF);
    wr(8'h00, 32'hFFFF_FFFF);
    wr(8'h0D, 32'hFFFF_FFFF);
    rd(A_CTL, d);  chk("R11 ctl unchanged", d, 32'h0123);
    rd(A_LANE, d); chk("R11 lane unchanged", d, 32'h1032);
    rd(8'h14, d);  chk("R11 stray read", d, 0);
    rd(8'h0D, d);  chk("R11 stray read", d, 0);
  endtask

  initial begin
    t_reset();
    t_defaults();
    t_codes(0, "R2 slot0");
    t_codes(1, "R3 slot1");
    t_codes(2, "R4 slot2");
    t_codes(3, "R5 slot3");
    t_unlisted();
    t_rotation();
    t_latency();
    t_write_timing();
    t_stray();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #500000;
    checks++;
    failures++;
    $display("FAIL watchdog expired actual=running expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule